// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer

This block is an 8-bit up-counter that is set up and read over a simple register bus. It holds two 8-bit compare constants. Each time the count arrives at one of them, a sticky match flag is set. That flag can raise an interrupt request and can move a timer output pin. An overflow flag marks the count wrapping past its top value and has its own interrupt request. A software handler clears a flag by reading it as set and then writing zero to it.

The counter advances on one of three internal prescaler taps or on edges of an external clock input. It can also be stopped. It can be cleared on match A, on match B, or on a rising edge of an external reset input, or never cleared. A bus write to a compare constant blocks the match detection of that constant for the write cycle. A match that arises in that cycle is lost.

Top module: `tmr_dual_compare`

## Requirements
- R1: After reset, the control register and the count read 0x00, both compare constants read 0xFF, all flags read 0, the timer output is 0 and every interrupt request is 0.
- R2: When the count comes to equal constant A (or B), flag A (or B) is set and stays set until it is cleared by software. The flags sit in the status register at bit 6 (A) and bit 7 (B).
- R3: If a bus write to a compare constant falls in the cycle where the count first equals that constant, no match is detected for it. The flag stays 0 while the count stays equal.
- R4: irqA is flag A AND control bit 6. irqB is flag B AND control bit 7. irqOvf is the overflow flag AND control bit 5.
- R5: Control bits 4:3 select the counter clear: 00 never, 01 on match A, 10 on match B, 11 on a rising edge of extRst. With a match clear the count never rises above the selected constant.
- R6: Control bits 2:0 select the count source. 000 and 100 stop the count. 001, 010 and 011 give one increment every 2^PRE_SH1, 2^PRE_SH2 and 2^PRE_SH3 cycles. 101, 110 and 111 give one increment per rising, falling or either edge of extClk.
- R7: Status bits 1:0 act on match A and bits 3:2 act on match B: 00 no change, 01 drive tmrOut low, 10 drive it high, 11 toggle it. Match B wins when both matches come in the same cycle.
- R8: The overflow flag (status bit 5) is set when an increment takes the count from 0xFF to 0x00.
- R9: A flag is cleared only by a status write with its bit 0 that follows a status read in which the flag was 1. A write of 1, or a write of 0 without such a read, leaves it set.
- R10: A bus write to the count takes effect even when an increment falls in the same cycle.
- R11: The register map is: 0 control, 1 status, 2 constant A, 3 constant B, 4 count. Every written register reads back its value, and status bit 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms flag clearing) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| extClk | input | 1 | External count clock |
| extRst | input | 1 | External counter clear |
| tmrOut | output | 1 | Timer output pin |
| irqA | output | 1 | Match A interrupt request |
| irqB | output | 1 | Match B interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with prescaler shifts of 3, 4 and 5 and keeps two synchroniser stages. With the short taps, an exact 64-cycle window checks all three divide ratios and an overflow run in a few hundred cycles. With the default shift of 13, the third tap would take 8192 cycles per step. The bench places back-to-back bus writes on exact cycles. This covers the blocked match, write priority over a tick at every prescaler phase, and simultaneous A/B matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CONA = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CONB = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic inc;
    logic blkA;
    logic blkB;
  } cntStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int PRE_SH1     = 3,
  parameter int PRE_SH2     = 6,
  parameter int PRE_SH3     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       stb,
  input  logic [REG_W-1:0] ldData,
  input  logic [REG_W-1:0] constA,
  input  logic [REG_W-1:0] constB,
  input  logic             extClk,
  input  logic             extRst,
  output logic [REG_W-1:0] count,
  output logic             evtA,
  output logic             evtB,
  output logic             wrap,
  output logic [2:0]       preTap,
  output logic             extRise,
  output logic             extFall,
  output logic             extRstRise
);
  localparam int PRE_W = PRE_SH3;

  logic [PRE_W-1:0]       pre;
  logic [SYNC_STAGES-1:0] clkSync, rstSync;
  logic                   clkLast, rstLast;
  logic                   prevA, prevB, rawA, rawB;

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else       pre <= pre + PRE_W'(1);
  end

  assign preTap = {&pre[PRE_SH3-1:0], &pre[PRE_SH2-1:0], &pre[PRE_SH1-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      rstSync <= '0;
      clkLast <= 1'b0;
      rstLast <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], extClk};
      rstSync <= {rstSync[SYNC_STAGES-2:0], extRst};
      clkLast <= clkSync[SYNC_STAGES-1];
      rstLast <= rstSync[SYNC_STAGES-1];
    end
  end

  assign extRise    =  clkSync[SYNC_STAGES-1] & ~clkLast;
  assign extFall    = ~clkSync[SYNC_STAGES-1] &  clkLast;
  assign extRstRise =  rstSync[SYNC_STAGES-1] & ~rstLast;

  // counter: load beats clear beats increment
  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (stb.load)  count <= ldData;
    else if (stb.clear) count <= '0;
    else if (stb.inc)   count <= count + REG_W'(1);
  end

  assign rawA = (count == constA);
  assign rawB = (count == constB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= rawA;
      prevB <= rawB;
    end
  end

  assign evtA = rawA & ~prevA & ~stb.blkA;
  assign evtB = rawB & ~prevB & ~stb.blkB;
  assign wrap = stb.inc & ~stb.load & ~stb.clear & (&count);

  // R10: a load always lands
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> count == $past(ldData));
  // R5: a clear without a load zeroes the count
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && !stb.load) |=> count == '0);
  // R6: with no strobe the count holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.load && !stb.clear) |=> $stable(count));
  // R8: a wrap lands on zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> count == '0);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [REG_W-1:0]  count,
  input  logic              evtA,
  input  logic              evtB,
  input  logic              wrap,
  input  logic [2:0]        preTap,
  input  logic              extRise,
  input  logic              extFall,
  input  logic              extRstRise,
  output cntStrobe_t        stb,
  output logic [REG_W-1:0]  constA,
  output logic [REG_W-1:0]  constB,
  output logic              tmrOut,
  output logic              irqA,
  output logic              irqB,
  output logic              irqOvf
);
  logic [REG_W-1:0] ctrlReg;
  logic [1:0]       osA, osB;
  logic             flagA, flagB, flagOvf;
  logic             armA, armB, armOvf;
  logic             statWr, statRd;

  assign statWr = wrEn && (addr == ADR_STAT);
  assign statRd = rdEn && (addr == ADR_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      constA  <= '1;
      constB  <= '1;
      osA     <= 2'b00;
      osB     <= 2'b00;
    end else if (wrEn) begin
      case (addr)
        ADR_CTRL: ctrlReg <= wrData;
        ADR_CONA: constA  <= wrData;
        ADR_CONB: constB  <= wrData;
        ADR_STAT: begin
          osA <= wrData[1:0];
          osB <= wrData[3:2];
        end
        default: ;
      endcase
    end
  end

  // count source select
  always_comb begin
    case (ctrlReg[2:0])
      3'b001:  stb.inc = preTap[0];
      3'b010:  stb.inc = preTap[1];
      3'b011:  stb.inc = preTap[2];
      3'b101:  stb.inc = extRise;
      3'b110:  stb.inc = extFall;
      3'b111:  stb.inc = extRise | extFall;
      default: stb.inc = 1'b0;
    endcase
    case (ctrlReg[4:3])
      2'b01:   stb.clear = evtA;
      2'b10:   stb.clear = evtB;
      2'b11:   stb.clear = extRstRise;
      default: stb.clear = 1'b0;
    endcase
    stb.load = wrEn && (addr == ADR_CNT);
    stb.blkA = wrEn && (addr == ADR_CONA);
    stb.blkB = wrEn && (addr == ADR_CONB);
  end

  // sticky flags: set wins over an armed zero write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {flagA, flagB, flagOvf} <= 3'b000;
      {armA, armB, armOvf}    <= 3'b000;
    end else begin
      if (evtA) flagA <= 1'b1;
      else if (statWr && armA && !wrData[6]) flagA <= 1'b0;
      if (evtB) flagB <= 1'b1;
      else if (statWr && armB && !wrData[7]) flagB <= 1'b0;
      if (wrap) flagOvf <= 1'b1;
      else if (statWr && armOvf && !wrData[5]) flagOvf <= 1'b0;
      if (statWr) {armA, armB, armOvf} <= 3'b000;
      else if (statRd) begin
        armA   <= armA | flagA;
        armB   <= armB | flagB;
        armOvf <= armOvf | flagOvf;
      end
    end
  end

  function automatic logic applySel(input logic cur, input logic [1:0] sel);
    case (sel)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN)     tmrOut <= 1'b0;
    else if (evtB) tmrOut <= applySel(tmrOut, osB);
    else if (evtA) tmrOut <= applySel(tmrOut, osA);
  end

  assign irqA   = flagA & ctrlReg[6];
  assign irqB   = flagB & ctrlReg[7];
  assign irqOvf = flagOvf & ctrlReg[5];

  always_comb begin
    case (addr)
      ADR_CTRL: rdData = ctrlReg;
      ADR_STAT: rdData = {flagB, flagA, flagOvf, 1'b0, osB, osA};
      ADR_CONA: rdData = constA;
      ADR_CONB: rdData = constB;
      ADR_CNT:  rdData = count;
      default:  rdData = '0;
    endcase
  end

  // R9: a flag only falls after a zero written to it
  a_r9_flaga_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagA) |-> $past(statWr && !wrData[6]));
  a_r9_flagovf_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagOvf) |-> $past(statWr && !wrData[5]));
  // R3: a constant write cycle cannot raise its flag
  a_r3_block_a: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_CONA && !flagA) |=> !flagA);
  // R7: the pin moves only on a match
  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(evtA || evtB) |=> $stable(tmrOut));
  // R2: flags are sticky without a status write
  a_r2_flagb_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagB && !statWr) |=> flagB);
endmodule

// File: rtl/tmr_dual_compare.sv
module tmr_dual_compare
  import tmr_pkg::*;
#(
  parameter int PRE_SH1     = 3,
  parameter int PRE_SH2     = 6,
  parameter int PRE_SH3     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        extClk,
  input  logic        extRst,
  output logic        tmrOut,
  output logic        irqA,
  output logic        irqB,
  output logic        irqOvf
);
  cntStrobe_t       stb;
  logic [REG_W-1:0] count, constA, constB;
  logic             evtA, evtB, wrap, extRise, extFall, extRstRise;
  logic [2:0]       preTap;

  tmr_ctrl ctrl_i (
    .clk, .rstN, .addr, .wrEn, .rdEn, .wrData, .rdData,
    .count, .evtA, .evtB, .wrap, .preTap, .extRise, .extFall, .extRstRise,
    .stb, .constA, .constB, .tmrOut, .irqA, .irqB, .irqOvf
  );

  tmr_datapath #(
    .PRE_SH1(PRE_SH1), .PRE_SH2(PRE_SH2), .PRE_SH3(PRE_SH3),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk, .rstN, .stb, .ldData(wrData), .constA, .constB, .extClk, .extRst,
    .count, .evtA, .evtB, .wrap, .preTap, .extRise, .extFall, .extRstRise
  );
endmodule

// File: tb/tmr_dual_compare_tb_top.sv
module tmr_dual_compare_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       extClk = 1'b0, extRst = 1'b0;
  logic       tmrOut, irqA, irqB, irqOvf;
  int         nChecks = 0, nFail = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  tmr_dual_compare #(.PRE_SH1(3), .PRE_SH2(4), .PRE_SH3(5), .SYNC_STAGES(2)) dut_i (
    .clk, .rstN, .addr, .wrEn, .rdEn, .wrData, .rdData,
    .extClk, .extRst, .tmrOut, .irqA, .irqB, .irqOvf
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all bus tasks enter and leave at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlags();
    logic [7:0] s;
    rd(3'd1, s);
    wr(3'd1, s & 8'h0F);
  endtask

  task automatic testReset();
    logic [7:0] d;
    rd(3'd0, d); chk("R1", "ctrl", d, 8'h00);
    rd(3'd1, d); chk("R1", "status", d, 8'h00);
    rd(3'd2, d); chk("R1", "constA", d, 8'hFF);
    rd(3'd3, d); chk("R1", "constB", d, 8'hFF);
    rd(3'd4, d); chk("R1", "count", d, 8'h00);
    chk("R1", "out/irqs", {tmrOut, irqA, irqB, irqOvf}, 0);
  endtask

  task automatic testReadback();
    logic [7:0] d;
    wr(3'd0, 8'hE0); wr(3'd2, 8'h3C); wr(3'd3, 8'hC3);
    wr(3'd1, 8'h1E); wr(3'd4, 8'h5A);
    rd(3'd0, d); chk("R11", "ctrl", d, 8'hE0);
    rd(3'd1, d); chk("R11", "status os bits, bit4 zero", d, 8'h0E);
    rd(3'd2, d); chk("R11", "constA", d, 8'h3C);
    rd(3'd3, d); chk("R11", "constB", d, 8'hC3);
    rd(3'd4, d); chk("R11", "count", d, 8'h5A);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic testMatch();
    logic [7:0] d;
    wr(3'd2, 8'h30); wr(3'd3, 8'h31);
    wr(3'd4, 8'h30); idle(2);
    rd(3'd1, d); chk("R2", "flags after match A", d[7:6], 2'b01);
    wr(3'd4, 8'h31); idle(2);
    rd(3'd1, d); chk("R2", "flags after match B", d[7:6], 2'b11);
    idle(5);
    rd(3'd1, d); chk("R2", "flags sticky", d[7:6], 2'b11);
    clearFlags();
    rd(3'd1, d); chk("R9", "flags cleared", d[7:6], 2'b00);
    // R3: constant rewrite in the match cycle
    wr(3'd2, 8'h20);
    wr(3'd4, 8'h20);
    wr(3'd2, 8'h20);
    idle(3);
    rd(3'd1, d); chk("R3", "blocked match A", d[6], 1'b0);
    wr(3'd4, 8'h21); wr(3'd4, 8'h20); idle(2);
    rd(3'd1, d); chk("R3", "unblocked match A", d[6], 1'b1);
  endtask

  task automatic testFlagClear();
    logic [7:0] d;
    wr(3'd0, 8'h40);
    chk("R4", "irqA enabled", irqA, 1'b1);
    chk("R4", "irqB flag clear", irqB, 1'b0);
    wr(3'd0, 8'h00);
    chk("R4", "irqA disabled", irqA, 1'b0);
    wr(3'd1, 8'h40);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R9", "write 1 / unarmed write 0 keep flag", d[6], 1'b1);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R9", "read-then-zero clears", d[6], 1'b0);
  endtask

  task automatic testOutput();
    wr(3'd1, 8'h06); wr(3'd2, 8'h40); wr(3'd3, 8'h50);
    wr(3'd4, 8'h40); idle(2); chk("R7", "A drives high", tmrOut, 1'b1);
    wr(3'd4, 8'h50); idle(2); chk("R7", "B drives low", tmrOut, 1'b0);
    wr(3'd1, 8'h07);
    wr(3'd4, 8'h40); idle(2); chk("R7", "A toggles up", tmrOut, 1'b1);
    wr(3'd4, 8'h41); wr(3'd4, 8'h40); idle(2);
    chk("R7", "A toggles down", tmrOut, 1'b0);
    wr(3'd1, 8'h06);
    wr(3'd4, 8'h41); wr(3'd4, 8'h40); idle(2);
    chk("R7", "A high again", tmrOut, 1'b1);
    wr(3'd3, 8'h40);
    wr(3'd4, 8'h41); wr(3'd4, 8'h40); idle(2);
    chk("R7", "B priority", tmrOut, 1'b0);
    wr(3'd1, 8'h00);
  endtask

  task automatic maxCount(input int n, output int mx);
    logic [7:0] d;
    mx = 0;
    for (int i = 0; i < n; i++) begin
      rd(3'd4, d);
      if (int'(d) > mx) mx = int'(d);
    end
  endtask

  task automatic testClear();
    int mx;
    logic [7:0] d;
    wr(3'd2, 8'h03); wr(3'd3, 8'h05);
    wr(3'd0, 8'h09); wr(3'd4, 8'h00);
    maxCount(100, mx); chk("R5", "clear on A max", mx, 3);
    wr(3'd0, 8'h11); wr(3'd4, 8'h00);
    maxCount(100, mx); chk("R5", "clear on B max", mx, 5);
    wr(3'd0, 8'h01); wr(3'd4, 8'h00);
    maxCount(100, mx); chk("R5", "no clear passes B", int'(mx > 5), 1);
    wr(3'd0, 8'h18); wr(3'd4, 8'h77); idle(4);
    rd(3'd4, d); chk("R5", "ext clear idle", d, 8'h77);
    extRst = 1'b1; idle(6);
    rd(3'd4, d); chk("R5", "ext clear edge", d, 8'h00);
    extRst = 1'b0; idle(4);
  endtask

  task automatic tapCase(input logic [7:0] ctl, input int exp, input string what);
    logic [7:0] d;
    wr(3'd0, ctl); wr(3'd4, 8'h00); idle(64);
    rd(3'd4, d); chk("R6", what, d, exp);
  endtask

  task automatic extCase(input logic [7:0] ctl, input int exp, input string what);
    logic [7:0] d;
    wr(3'd0, ctl); wr(3'd4, 8'h00);
    for (int i = 0; i < 3; i++) begin
      extClk = 1'b1; idle(6);
      extClk = 1'b0; idle(6);
    end
    rd(3'd4, d); chk("R6", what, d, exp);
  endtask

  task automatic testClock();
    wr(3'd2, 8'hF0); wr(3'd3, 8'hF0);
    tapCase(8'h00, 0, "stopped 000");
    tapCase(8'h04, 0, "stopped 100");
    tapCase(8'h01, 8, "tap 1");
    tapCase(8'h02, 4, "tap 2");
    tapCase(8'h03, 2, "tap 3");
    extCase(8'h05, 3, "ext rising");
    extCase(8'h06, 3, "ext falling");
    extCase(8'h07, 6, "ext both");
  endtask

  task automatic testWritePriority();
    logic [7:0] d;
    wr(3'd0, 8'h01);
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, 8'(8'h80 + 3 * i));
      rd(3'd4, d);
      chk("R10", "load vs tick", d, 8'h80 + 3 * i);
      idle(1);
    end
  endtask

  task automatic testOverflow();
    logic [7:0] d;
    rd(3'd1, d); chk("R8", "no overflow yet", d[5], 1'b0);
    wr(3'd0, 8'h01); wr(3'd4, 8'hFD); idle(64);
    rd(3'd4, d); chk("R8", "count wrapped", d, 8'h05);
    rd(3'd1, d); chk("R8", "overflow flag", d[5], 1'b1);
    chk("R4", "irqOvf disabled", irqOvf, 1'b0);
    wr(3'd0, 8'h21);
    chk("R4", "irqOvf enabled", irqOvf, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testReadback();
    testMatch();
    testFlagClear();
    testOutput();
    testClear();
    testClock();
    testWritePriority();
    testOverflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule